// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches the 32 input pins of one general-purpose I/O bank and turns pin activity into a single interrupt request. Each pin has its own trigger mode, chosen from rising edge, falling edge, both edges, high level or low level. The mode is set by three independent configuration bits per pin: a kind bit (edge or level), a sense bit (rising/high or falling/low) and a dual-edge bit. Pin inputs arrive already synchronised to the block clock. An edge is found by comparing each pin with its value on the previous cycle.

Detected events collect in a sticky pending register, and software clears it by writing ones. A read-only mask register gates which pending bits reach the bank interrupt line. Two write-only strobe addresses change the mask: one clears mask bits and the other sets them. Detection does not stop while a pin is masked. An event that arrives during masking stays pending and raises the interrupt as soon as the pin is unmasked.

Software reaches the block over a simple synchronous bus. Writes take effect at the clock edge where the write strobe is high. Read data is a combinational function of the word address.

Top module: `gpio_irq_bank`

## Requirements
- R1: Synchronous active-low reset sets the mask to all ones and clears pending, kind, sense and dual-edge. The interrupt line is low after reset.
- R2: A pin with kind=1, sense=1 and dual=0 sets its pending bit one clock after a 0-to-1 pin transition, and not on a 1-to-0 transition.
- R3: A pin with kind=1, sense=0 and dual=0 sets its pending bit on a 1-to-0 transition only.
- R4: A pin with kind=1 and dual=1 sets its pending bit on both transitions, whatever its sense bit is.
- R5: A pin with kind=0 sets its pending bit on every cycle its active level is present: high for sense=1, low for sense=0. The dual-edge bit has no effect on a level pin.
- R6: Writing word address 1 (pending) clears each pending bit where the data bit is 1, and zero bits have no effect. If a new event hits a bit in the same cycle as its clear, the bit stays set.
- R7: Writing ones to word address 2 clears those mask bits, and writing ones to word address 3 sets them. Zero bits written to either address change nothing. Writing all ones to address 3 masks every pin.
- R8: irq_out is high exactly when some pending bit has its mask bit at 0. Events on masked pins are still latched, and they raise irq_out once the pin is unmasked.
- R9: Word addresses 4 (kind), 5 (sense) and 6 (dual-edge) read back what was written. Word address 0 reads the mask (1 = masked) and ignores writes.
- R10: Reads of word addresses 2, 3 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Synchronised pin levels |
| irq_out | output | 1 | Bank interrupt request |

## Verification
The bound checker watches four things on every cycle:
- that no detector event is ever lost from the pending register;
- that pending bits survive any cycle in which no clear is written;
- that a mask-all write silences the interrupt and an unmask write clears exactly the written mask bits;
- that the configuration registers hold their value when they are not written.

Only the directed scenarios can show which pin transitions count as events in each of the five trigger modes. The same is true of the level-mode race where a clear loses to a still-present level, the dual-edge bit being ignored for level pins, and an event captured while masked reaching irq_out on unmask.

// File: rtl/gpio_irq_pkg.sv
// Package: shared constants for the GPIO bank interrupt detector.
// Holds the register word indices used by the bus decoder.
package gpio_irq_pkg;
    localparam int IDX_MASK    = 0;  // read-only mask, 1 = masked
    localparam int IDX_PEND    = 1;  // pending, write one to clear
    localparam int IDX_UNMASK  = 2;  // write-one strobe, clears mask bits
    localparam int IDX_MASKSET = 3;  // write-one strobe, sets mask bits
    localparam int IDX_KIND    = 4;  // 1 = edge, 0 = level
    localparam int IDX_SENSE   = 5;  // 1 = rising/high, 0 = falling/low
    localparam int IDX_DUAL    = 6;  // 1 = both edges (edge kind only)

    typedef struct packed {
        logic kind;
        logic sense;
        logic dual;
    } pin_mode_t;
endpackage

// File: rtl/gpio_irq_regs.sv
// Module: gpio_irq_regs
// Holds the per-pin mode registers and the mask register. It decodes bus
// writes into configuration updates, mask strobes and pending-clear
// vectors, and drives the read mux.
// Assumes single-cycle writes qualified by bus_wr. Reads are combinational.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    input  logic [NPINS-1:0]  pend_q,
    output logic [NPINS-1:0]  kind_q,
    output logic [NPINS-1:0]  sense_q,
    output logic [NPINS-1:0]  dual_q,
    output logic [NPINS-1:0]  mask_q,
    output logic [NPINS-1:0]  clr_vec,
    output logic [NPINS-1:0]  bus_rdata
);
    localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(IDX_MASK);
    localparam logic [ADDR_W-1:0] A_PEND    = ADDR_W'(IDX_PEND);
    localparam logic [ADDR_W-1:0] A_UNMASK  = ADDR_W'(IDX_UNMASK);
    localparam logic [ADDR_W-1:0] A_MASKSET = ADDR_W'(IDX_MASKSET);
    localparam logic [ADDR_W-1:0] A_KIND    = ADDR_W'(IDX_KIND);
    localparam logic [ADDR_W-1:0] A_SENSE   = ADDR_W'(IDX_SENSE);
    localparam logic [ADDR_W-1:0] A_DUAL    = ADDR_W'(IDX_DUAL);

    logic wr_kind, wr_sense, wr_dual, wr_unmask, wr_maskset, wr_pend;

    // Purpose: one-hot decode of the write address.
    always_comb begin
        wr_kind    = bus_wr && (bus_addr == A_KIND);
        wr_sense   = bus_wr && (bus_addr == A_SENSE);
        wr_dual    = bus_wr && (bus_addr == A_DUAL);
        wr_unmask  = bus_wr && (bus_addr == A_UNMASK);
        wr_maskset = bus_wr && (bus_addr == A_MASKSET);
        wr_pend    = bus_wr && (bus_addr == A_PEND);
    end

    // Purpose: per-bit clear request toward the pending register.
    assign clr_vec = wr_pend ? bus_wdata : '0;

    // Purpose: mode registers, plain read/write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= '0;
            sense_q <= '0;
            dual_q  <= '0;
        end else begin
            if (wr_kind)  kind_q  <= bus_wdata;
            if (wr_sense) sense_q <= bus_wdata;
            if (wr_dual)  dual_q  <= bus_wdata;
        end
    end

    // Purpose: mask register, changed only through the two strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (wr_unmask) begin
            mask_q <= mask_q & ~bus_wdata;
        end else if (wr_maskset) begin
            mask_q <= mask_q | bus_wdata;
        end
    end

    // Purpose: read mux, strobe and unused addresses return zero.
    always_comb begin
        unique case (bus_addr)
            A_MASK:  bus_rdata = mask_q;
            A_PEND:  bus_rdata = pend_q;
            A_KIND:  bus_rdata = kind_q;
            A_SENSE: bus_rdata = sense_q;
            A_DUAL:  bus_rdata = dual_q;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_detect.sv
// Module: gpio_irq_detect
// Per-pin trigger evaluation. Each pin keeps its previous-cycle level, and
// its mode bits pick an edge or level condition. The result is a
// one-cycle event vector.
// Assumes pin_in is already synchronised to clk.
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] kind_q,
    input  logic [NPINS-1:0] sense_q,
    input  logic [NPINS-1:0] dual_q,
    output logic [NPINS-1:0] evt
);
    logic [NPINS-1:0] prev_q;

    // Purpose: remember last-cycle pin levels, also during reset so no
    // spurious edge appears when reset is released.
    always_ff @(posedge clk) begin
        prev_q <= pin_in;
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        pin_mode_t mode;
        logic      rise, fall, edge_hit, level_hit;

        // Purpose: evaluate this pin's trigger condition.
        always_comb begin
            mode      = '{kind: kind_q[p], sense: sense_q[p], dual: dual_q[p]};
            rise      = pin_in[p] & ~prev_q[p];
            fall      = ~pin_in[p] & prev_q[p];
            edge_hit  = mode.dual ? (rise | fall) : (mode.sense ? rise : fall);
            level_hit = mode.sense ? pin_in[p] : ~pin_in[p];
            evt[p]    = mode.kind ? edge_hit : level_hit;
        end
    end
endmodule

// File: rtl/gpio_irq_status.sv
// Module: gpio_irq_status
// Sticky pending register with write-one-to-clear and the masked OR that
// forms the bank interrupt. A new event beats a clear on the same bit.
// Assumes clr_vec is a single-cycle request.
module gpio_irq_status #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] evt,
    input  logic [NPINS-1:0] clr_vec,
    input  logic [NPINS-1:0] mask_q,
    output logic [NPINS-1:0] pend_q,
    output logic             irq_out
);
    // Purpose: latch events, drop cleared bits unless re-hit this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_vec) | evt;
        end
    end

    // Purpose: interrupt request from pending bits that are not masked.
    assign irq_out = |(pend_q & ~mask_q);
endmodule

// File: rtl/gpio_irq_bank.sv
// Module: gpio_irq_bank (top)
// Interrupt detection for one GPIO bank: register decode, per-pin trigger
// evaluation and the pending/mask logic behind a single interrupt line.
// Assumes synchronised pin inputs and a single-cycle write bus.
module gpio_irq_bank #(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic              irq_out
);
    logic [NPINS-1:0] kind_q, sense_q, dual_q, mask_q, clr_vec, pend_q, evt_vec;

    gpio_irq_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pend_q    (pend_q),
        .kind_q    (kind_q),
        .sense_q   (sense_q),
        .dual_q    (dual_q),
        .mask_q    (mask_q),
        .clr_vec   (clr_vec),
        .bus_rdata (bus_rdata)
    );

    gpio_irq_detect #(.NPINS(NPINS)) i_detect (
        .clk     (clk),
        .pin_in  (pin_in),
        .kind_q  (kind_q),
        .sense_q (sense_q),
        .dual_q  (dual_q),
        .evt     (evt_vec)
    );

    gpio_irq_status #(.NPINS(NPINS)) i_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_vec),
        .clr_vec (clr_vec),
        .mask_q  (mask_q),
        .pend_q  (pend_q),
        .irq_out (irq_out)
    );
endmodule

// File: rtl/gpio_irq_checker.sv
// Module: gpio_irq_checker
// Concurrent checks bound to gpio_irq_bank. Observes ports and the state
// registers that separate submodules drive.
module gpio_irq_checker
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic              irq_out,
    input logic [NPINS-1:0]  mask_q,
    input logic [NPINS-1:0]  pend_q,
    input logic [NPINS-1:0]  evt_vec,
    input logic [NPINS-1:0]  kind_q
);
    // R1: state right after a reset cycle
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (mask_q == '1 && pend_q == '0 && kind_q == '0));

    // R6: every detector event lands in pending on the next edge
    p_event_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vec != '0) |=> (($past(evt_vec) & ~pend_q) == '0));

    // R6: with no clear written, pending bits never drop
    p_pend_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'(IDX_PEND))
        |=> (($past(pend_q) & ~pend_q) == '0));

    // R7: mask-all write silences the interrupt line
    p_mask_all_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(IDX_MASKSET) && bus_wdata == '1)
        |=> !irq_out);

    // R7: unmask strobe clears exactly the written bits' mask
    p_unmask_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(IDX_UNMASK))
        |=> ((mask_q & $past(bus_wdata)) == '0
             && (mask_q | $past(bus_wdata)) == ($past(mask_q) | $past(bus_wdata))));

    // R9: kind register only moves on its own write
    p_kind_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'(IDX_KIND)) |=> $stable(kind_q));
endmodule

bind gpio_irq_bank gpio_irq_checker #(.NPINS(NPINS), .ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_out   (irq_out),
    .mask_q    (mask_q),
    .pend_q    (pend_q),
    .evt_vec   (evt_vec),
    .kind_q    (kind_q)
);

// File: tb/test_gpio_irq_bank.sv
// Directed bench for gpio_irq_bank. All inputs change just after a falling
// edge. Outputs are sampled 1 ns later, away from the rising edge.
module test_gpio_irq_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '1;
    logic        irq_out;
    int          total = 0;
    int          bad = 0;

    always #4 clk = ~clk;  // 125 MHz

    gpio_irq_bank i_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        step();
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic set_pins(input logic [31:0] v);
        step();
        pin_in = v;
        step();  // event latched at the rising edge in between
    endtask

    task automatic t_reset();
        rd_chk("R1 mask", 3'd0, 32'hFFFF_FFFF);
        rd_chk("R1 pending", 3'd1, 32'h0);
        rd_chk("R1 kind", 3'd4, 32'h0);
        rd_chk("R1 sense", 3'd5, 32'h0);
        rd_chk("R1 dual", 3'd6, 32'h0);
        chk("R1 irq", {31'd0, irq_out}, 32'd0);
    endtask

    task automatic t_config();
        // all pins edge/falling; pin0 rising; pin2 dual; pin3 level with dual set
        wr(3'd4, 32'hFFFF_FFF7);
        wr(3'd5, 32'h0000_0001);
        wr(3'd6, 32'h0000_000C);
        step();
        rd_chk("R9 kind readback", 3'd4, 32'hFFFF_FFF7);
        rd_chk("R9 sense readback", 3'd5, 32'h0000_0001);
        rd_chk("R9 dual readback", 3'd6, 32'h0000_000C);
        rd_chk("R5 level low pin high, quiet", 3'd1, 32'h0);
    endtask

    task automatic t_rising();
        set_pins(32'hFFFF_FFFE);
        rd_chk("R2 fall ignored", 3'd1, 32'h0);
        set_pins(32'hFFFF_FFFF);
        rd_chk("R2 rise latched", 3'd1, 32'h1);
        chk("R8 masked no irq", {31'd0, irq_out}, 32'd0);
        wr(3'd1, 32'h0);
        rd_chk("R6 zero write no effect", 3'd1, 32'h1);
        wr(3'd1, 32'h1);
        rd_chk("R6 clear", 3'd1, 32'h0);
    endtask

    task automatic t_falling();
        set_pins(32'hFFFF_FFFD);
        rd_chk("R3 fall latched", 3'd1, 32'h2);
        wr(3'd1, 32'h2);
        set_pins(32'hFFFF_FFFF);
        rd_chk("R3 rise ignored", 3'd1, 32'h0);
    endtask

    task automatic t_dual();
        set_pins(32'hFFFF_FFFB);
        rd_chk("R4 dual fall", 3'd1, 32'h4);
        wr(3'd1, 32'h4);
        set_pins(32'hFFFF_FFFF);
        rd_chk("R4 dual rise", 3'd1, 32'h4);
        wr(3'd1, 32'h4);
        rd_chk("R4 cleared", 3'd1, 32'h0);
    endtask

    task automatic t_level();
        wr(3'd5, 32'h0000_0009);  // pin3 level high, pin high
        step();
        rd_chk("R5 level high set", 3'd1, 32'h8);
        wr(3'd1, 32'h8);
        rd_chk("R6 event beats clear", 3'd1, 32'h8);
        set_pins(32'hFFFF_FFF7);
        rd_chk("R5 level gone stays", 3'd1, 32'h8);
        wr(3'd1, 32'h8);
        step();
        rd_chk("R5 clear sticks", 3'd1, 32'h0);
    endtask

    task automatic t_mask();
        set_pins(32'hFFFF_FFFE);
        set_pins(32'hFFFF_FFFF);  // pin0 rise while masked
        chk("R8 masked event no irq", {31'd0, irq_out}, 32'd0);
        wr(3'd0, 32'h0);
        rd_chk("R9 mask read-only", 3'd0, 32'hFFFF_FFFF);
        wr(3'd2, 32'h1);
        rd_chk("R7 unmask bit0", 3'd0, 32'hFFFF_FFFE);
        chk("R8 irq on unmask", {31'd0, irq_out}, 32'd1);
        wr(3'd2, 32'h0);
        wr(3'd3, 32'h0);
        rd_chk("R7 zero strobes", 3'd0, 32'hFFFF_FFFE);
        rd_chk("R10 unmask reads zero", 3'd2, 32'h0);
        rd_chk("R10 maskset reads zero", 3'd3, 32'h0);
        rd_chk("R10 spare reads zero", 3'd7, 32'h0);
        wr(3'd3, 32'hFFFF_FFFF);
        rd_chk("R7 mask all", 3'd0, 32'hFFFF_FFFF);
        chk("R7 mask all quiet", {31'd0, irq_out}, 32'd0);
        wr(3'd2, 32'h1);
        chk("R8 irq again", {31'd0, irq_out}, 32'd1);
        wr(3'd1, 32'h1);
        chk("R8 irq drops on clear", {31'd0, irq_out}, 32'd0);
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_config();
        t_rising();
        t_falling();
        t_dual();
        t_level();
        t_mask();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule